// File: doc/BRIEF.md
# Three-and-a-half digit segment display driver

This block turns a held meter reading into the signals for a direct-drive liquid crystal panel. The reading arrives as three decimal digits in BCD, a leading-one flag for the half digit, a sign flag and an overrange flag. A lamp-test input lights every segment. The block drives one 7-segment group for each of the units, tens and hundreds digits. A single line serves both segments of the leading "1", and one more line drives the minus sign.

In the default liquid crystal mode, a shared backplane line is a square wave made by dividing the clock. Each segment line carries the same square wave: in phase with the backplane when the segment is dark, and inverted when it is lit. The glass therefore never sees a DC voltage. New segment states are taken only on the clock edge where the backplane flips, so a segment line never glitches between transitions. A parameter selects an LED build instead. In that build the backplane is held low and each segment line is a static active-low sink for a common-anode display.

Top module: `lcd_meter_drive`

## Requirements
- R1: After reset the backplane is low. It then toggles once every HALF_PERIOD clocks (default 400), giving a period of twice HALF_PERIOD clocks.
- R2: In liquid crystal mode a dark segment line equals the backplane and a lit segment line equals its inverse.
- R3: Digit groups use bit 0 = a through bit 6 = g. The lit patterns for codes 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R4: BCD codes 10 to 15 leave their digit fully dark.
- R5: The single leading-one line is lit exactly when the leading-one input is high.
- R6: The minus line is lit exactly when the sign input is high.
- R7: When overrange is set, the three lower digits are dark and the leading-one line is lit whatever its input is. The minus line still follows the sign.
- R8: Lamp test lights every segment, the leading-one line and the minus line, and it takes priority over overrange.
- R9: Segment lines and the backplane change only on the clock edge that ends a divider half period. Input changes at any other time have no effect until that edge.
- R10: With LED_MODE set, the backplane stays low and every segment line is low when lit and high when dark.
- R11: During and just after reset every segment line shows dark: low in liquid crystal mode, high in LED mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| units_bcd | input | 4 | Units digit, BCD |
| tens_bcd | input | 4 | Tens digit, BCD |
| hund_bcd | input | 4 | Hundreds digit, BCD |
| lead_one | input | 1 | Half digit shows "1" |
| negative | input | 1 | Reading is negative |
| overrange | input | 1 | Reading exceeds full scale |
| lamp_test | input | 1 | Force all segments lit |
| seg_units | output | 7 | Units segments a..g |
| seg_tens | output | 7 | Tens segments a..g |
| seg_hund | output | 7 | Hundreds segments a..g |
| seg_lead | output | 1 | Shared b/c line of the leading "1" |
| seg_minus | output | 1 | Minus sign segment |
| backplane | output | 1 | Common backplane drive |

## Verification
The assertions assume the reading inputs are held steady across the divider edge that captures them. They check the outcome one cycle after that edge. The bench therefore changes inputs only on falling clock edges, and waits at least one full half period before it compares. It takes one deliberate change just after a backplane flip to show that nothing moves before the next flip. Two builds run side by side with short half periods: one in liquid crystal mode and one in LED mode. The sweep covers every code for each digit, in both backplane phases.

// File: rtl/lcd_meter_drive.sv
module lcd_meter_drive #(
  parameter int HALF_PERIOD = 400,
  parameter bit LED_MODE    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] units_bcd,
  input  logic [3:0] tens_bcd,
  input  logic [3:0] hund_bcd,
  input  logic       lead_one,
  input  logic       negative,
  input  logic       overrange,
  input  logic       lamp_test,
  output logic [6:0] seg_units,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_hund,
  output logic       seg_lead,
  output logic       seg_minus,
  output logic       backplane
);
  localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  function automatic logic [6:0] decode(input logic [3:0] d);
    case (d)
      4'd0: decode = 7'h3F;
      4'd1: decode = 7'h06;
      4'd2: decode = 7'h5B;
      4'd3: decode = 7'h4F;
      4'd4: decode = 7'h66;
      4'd5: decode = 7'h6D;
      4'd6: decode = 7'h7D;
      4'd7: decode = 7'h07;
      4'd8: decode = 7'h7F;
      4'd9: decode = 7'h6F;
      default: decode = 7'h00;
    endcase
  endfunction

  logic [CW-1:0] div_q;
  logic          tick;
  logic          bp_nx;
  logic          inv;
  logic [6:0]    lit_u, lit_t, lit_h;
  logic          lit_lead, lit_minus;

  assign tick  = (div_q == LAST);
  assign bp_nx = LED_MODE ? 1'b0 : ~backplane;
  assign inv   = LED_MODE ? 1'b1 : bp_nx;

  always_comb begin
    if (lamp_test) begin
      lit_u = 7'h7F; lit_t = 7'h7F; lit_h = 7'h7F;
      lit_lead = 1'b1; lit_minus = 1'b1;
    end else if (overrange) begin
      lit_u = 7'h00; lit_t = 7'h00; lit_h = 7'h00;
      lit_lead = 1'b1; lit_minus = negative;
    end else begin
      lit_u = decode(units_bcd);
      lit_t = decode(tens_bcd);
      lit_h = decode(hund_bcd);
      lit_lead = lead_one; lit_minus = negative;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      backplane <= 1'b0;
      seg_units <= {7{LED_MODE}};
      seg_tens  <= {7{LED_MODE}};
      seg_hund  <= {7{LED_MODE}};
      seg_lead  <= LED_MODE;
      seg_minus <= LED_MODE;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        backplane <= bp_nx;
        seg_units <= lit_u ^ {7{inv}};
        seg_tens  <= lit_t ^ {7{inv}};
        seg_hund  <= lit_h ^ {7{inv}};
        seg_lead  <= lit_lead ^ inv;
        seg_minus <= lit_minus ^ inv;
      end
    end
  end

  assert_bp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(backplane));
  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(seg_units) && $stable(seg_tens) && $stable(seg_hund)
               && $stable(seg_lead) && $stable(seg_minus)));

  generate
    if (LED_MODE) begin : g_led_chk
      assert_no_backplane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        backplane == 1'b0);
      assert_lamp_led_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lamp_test) |=> (seg_units == 7'h00 && seg_lead == 1'b0));
    end else begin : g_lcd_chk
      assert_bp_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (backplane != $past(backplane)));
      assert_lamp_lcd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lamp_test) |=> (seg_units == {7{~backplane}} && seg_minus == ~backplane));
      assert_over_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && overrange && !lamp_test) |=>
          (seg_hund == {7{backplane}} && seg_lead == ~backplane));
    end
  endgenerate
endmodule

// File: tb/lcd_meter_drive_tb_top.sv
module lcd_meter_drive_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] u_d = 0, t_d = 0, h_d = 0;
  logic lead = 0, neg = 0, ovr = 0, lamp = 0;
  logic [6:0] c_u, c_t, c_h, e_u, e_t, e_h;
  logic c_l, c_m, c_bp, e_l, e_m, e_bp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_meter_drive #(.HALF_PERIOD(4), .LED_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .units_bcd(u_d), .tens_bcd(t_d), .hund_bcd(h_d),
    .lead_one(lead), .negative(neg), .overrange(ovr), .lamp_test(lamp),
    .seg_units(c_u), .seg_tens(c_t), .seg_hund(c_h), .seg_lead(c_l),
    .seg_minus(c_m), .backplane(c_bp));

  lcd_meter_drive #(.HALF_PERIOD(3), .LED_MODE(1'b1)) led_i (
    .clk(clk), .rst_n(rst_n), .units_bcd(u_d), .tens_bcd(t_d), .hund_bcd(h_d),
    .lead_one(lead), .negative(neg), .overrange(ovr), .lamp_test(lamp),
    .seg_units(e_u), .seg_tens(e_t), .seg_hund(e_h), .seg_lead(e_l),
    .seg_minus(e_m), .backplane(e_bp));

  function automatic logic [6:0] pat(input logic [3:0] d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
      4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
      8: pat = 7'h7F; 9: pat = 7'h6F; default: pat = 7'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [6:0] lu, lt, lh;
    logic ll, lm;
    if (lamp) begin
      lu = 7'h7F; lt = 7'h7F; lh = 7'h7F; ll = 1; lm = 1;
    end else if (ovr) begin
      lu = 0; lt = 0; lh = 0; ll = 1; lm = neg;
    end else begin
      lu = pat(u_d); lt = pat(t_d); lh = pat(h_d); ll = lead; lm = neg;
    end
    chk({req, " R2 lcd"}, {c_u, c_t, c_h, c_l, c_m},
        {lu ^ {7{c_bp}}, lt ^ {7{c_bp}}, lh ^ {7{c_bp}}, ll ^ c_bp, lm ^ c_bp});
    chk({req, " R10 led"}, {e_bp, e_u, e_t, e_h, e_l, e_m},
        {1'b0, ~lu, ~lt, ~lh, ~ll, ~lm});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic bp0;
    int cnt;
    wait_neg(3);
    chk("R11 lcd reset", {c_bp, c_u, c_t, c_h, c_l, c_m}, 24'h0);
    chk("R11 led reset", {e_bp, e_u, e_t, e_h, e_l, e_m}, {1'b0, 23'h7FFFFF});
    rst_n = 1'b1;
    wait_neg(2);
    chk("R11 after reset", {c_bp, c_u}, 8'h0);
    // R1: measure half period
    bp0 = c_bp;
    while (c_bp == bp0) @(negedge clk);
    bp0 = c_bp; cnt = 0;
    while (c_bp == bp0) begin @(negedge clk); cnt++; end
    chk("R1 half period", cnt, 4);
    // R3 R4 R5 R6 sweep
    for (int c = 0; c < 16; c++) begin
      u_d = 4'(c); t_d = 4'(c + 5); h_d = 4'(c + 11);
      lead = c[0]; neg = c[1];
      wait_neg(8 + 4 * (c % 2));
      check_all("R3 R4 R5 R6 digit sweep");
    end
    // R7 overrange with sign and lead variations
    ovr = 1;
    for (int c = 0; c < 8; c++) begin
      u_d = 4'(c); t_d = 4'(9 - c); h_d = 4'(c + 1); lead = c[0]; neg = c[1];
      wait_neg(8 + 4 * (c % 2));
      check_all("R7 overrange");
    end
    // R8 lamp test over both overrange states
    lamp = 1;
    for (int c = 0; c < 4; c++) begin
      ovr = c[0]; neg = c[1]; lead = 0; u_d = 4'(c + 10);
      wait_neg(8 + 4 * (c % 2));
      check_all("R8 lamp test");
    end
    lamp = 0; ovr = 0;
    // R9: change right after a flip, outputs hold until next flip
    u_d = 4'd1; t_d = 4'd2; h_d = 4'd3; lead = 0; neg = 0;
    wait_neg(10);
    bp0 = c_bp;
    while (c_bp == bp0) @(negedge clk);
    u_d = 4'd8; t_d = 4'd8; h_d = 4'd8; lead = 1; neg = 1;
    wait_neg(2);
    chk("R9 hold lcd", {c_u, c_l}, {pat(4'd1) ^ {7{c_bp}}, c_bp});
    wait_neg(3);
    chk("R9 update lcd", {c_u, c_l}, {pat(4'd8) ^ {7{c_bp}}, ~c_bp});
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule